// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Decade Counter

This block counts pulses through ten states using a five-stage twisted-ring (Johnson) register. Each state lights exactly one of ten decoded outputs, and an active-low carry shows whether the count is in its upper half. Two count inputs of opposite edge sense gate one another, so either one can act as the count source while the other acts as an enable. Both inputs are brought into the single system clock domain through two-flop synchronisers, and their edges are found there. As a result, the state register is fully synchronous. The only exception is the master reset, which is applied asynchronously and released synchronously.

The state register moves through the named states S0..S9. The transitions are:
- *advance*: Sk goes to S(k+1), and S9 wraps to S0.
- *hold*: the state is unchanged.
- *recover*: any illegal code goes to S0.
- *load*: a synchronous seed write.
- *reset*: asynchronous, to S0.

The count qualifier is a small event machine. It classifies each system clock as EV_IDLE, EV_RISE, EV_FALL or EV_BOTH, and every event other than EV_IDLE produces exactly one advance. The carry output can feed the rising-edge count input of a further counter, so several counters can be chained.

Top module: `jc_decade_counter`

## Requirements
- R1: The state codes (bit 4 down to bit 0) are S0=00000, S1=00001, S2=00011, S3=00111, S4=01111, S5=11111, S6=11110, S7=11100, S8=11000 and S9=10000. Each advance moves Sk to S(k+1), and S9 wraps to S0.
- R2: A low-to-high change on `cnt_rise_i` while `cnt_fall_i` is low advances the counter by one. The outputs show the new state after the third rising system clock edge following the input change.
- R3: A high-to-low change on `cnt_fall_i` while `cnt_rise_i` is high advances the counter by one, with the same latency as R2.
- R4: Every other input activity leaves the state unchanged. This covers a rising `cnt_rise_i` while `cnt_fall_i` is high, a falling `cnt_fall_i` while `cnt_rise_i` is low, a falling `cnt_rise_i`, a rising `cnt_fall_i`, and steady levels.
- R5: When a qualifying rising change on `cnt_rise_i` and a qualifying falling change on `cnt_fall_i` land in the same system clock, the counter advances exactly once.
- R6: While `mr_i` is high, the outputs show S0 (`dec_o` = 0000000001, `carry_n_o` = 1). They do so without waiting for a clock edge, and no count input has any effect.
- R7: After `mr_i` falls, the first qualifying count edge advances the counter exactly once, to S1.
- R8: In state Sk, bit k of `dec_o` is high and all other bits of `dec_o` are low.
- R9: `carry_n_o` is low in S5..S9 and high in S0..S4.
- R10: A high `seed_load_i` at a system clock edge writes `seed_i` into the state register. The load takes priority over a count in the same clock.
- R11: From any illegal five-bit code, the next count moves the counter to S0. This is well inside the bound of 11 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr_i | input | 1 | Master reset, active high, asynchronous assert |
| cnt_rise_i | input | 1 | Count input, counts on its rising change |
| cnt_fall_i | input | 1 | Count input, counts on its falling change |
| seed_load_i | input | 1 | Synchronous load strobe for the state register |
| seed_i | input | 5 | Code written on load |
| dec_o | output | 10 | One-hot decoded state |
| carry_n_o | output | 1 | Low in the upper five states |

## Verification
The assertions assume that each count input is a slow level signal that holds for at least three system clocks after every change. They also assume that `mr_i` is released while both count inputs are steady, so that the synchronised history describes real edges. The stimulus changes inputs only on falling clock edges and waits four clocks after every change. It releases the reset with both count inputs low. The one-hot and carry checks apply only to legal codes, because a loaded illegal code is allowed to decode to any pattern until the next count.

// File: rtl/jc_pkg.sv
package jc_pkg;
    localparam int DEF_STAGES = 5;
    localparam int DEF_SYNC   = 2;

    typedef enum logic [1:0] {
        EV_IDLE = 2'b00,
        EV_RISE = 2'b01,
        EV_FALL = 2'b10,
        EV_BOTH = 2'b11
    } cnt_event_e;
endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = DEPTH - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[DEPTH-2:0], d_i[b]};
        end
        assign q_o[b] = chain[LAST];
    end
endmodule

// File: rtl/jc_reset_sync.sv
module jc_reset_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic arst_i,
    output logic rst_n_o
);
    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], 1'b1};
    end

    assign rst_n_o = stage[DEPTH-1];
endmodule

// File: rtl/jc_count_qual.sv
module jc_count_qual
    import jc_pkg::*;
(
    input  logic clk,
    input  logic rise_s_i,
    input  logic fall_s_i,
    output logic adv_o
);
    logic       rise_q;
    logic       fall_q;
    cnt_event_e ev;

    // history register
    always_ff @(posedge clk) begin
        rise_q <= rise_s_i;
        fall_q <= fall_s_i;
    end

    // event classification
    always_comb begin
        ev = cnt_event_e'({(fall_q & ~fall_s_i & rise_s_i),
                           (rise_s_i & ~rise_q & ~fall_s_i)});
    end

    // output decision: one advance per clock at most
    always_comb begin
        unique case (ev)
            EV_IDLE: adv_o = 1'b0;
            EV_RISE: adv_o = 1'b1;
            EV_FALL: adv_o = 1'b1;
            EV_BOTH: adv_o = 1'b1;
            default: adv_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/jc_ring_core.sv
module jc_ring_core #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              load_i,
    input  logic [STAGES-1:0] seed_i,
    output logic [STAGES-1:0] q_o,
    output logic              legal_o
);
    localparam int TOP = STAGES - 1;

    typedef enum logic [1:0] {
        TR_HOLD    = 2'd0,
        TR_ADVANCE = 2'd1,
        TR_RECOVER = 2'd2,
        TR_LOAD    = 2'd3
    } trans_e;

    logic [STAGES-1:0] q;
    logic [STAGES-1:0] q_nxt;
    trans_e            tr;

    // a code is legal when it has at most one boundary between adjacent bits
    function automatic logic is_legal(input logic [STAGES-1:0] c);
        int changes;
        changes = 0;
        for (int i = 0; i < TOP; i++) begin
            if (c[i] != c[i+1]) changes++;
        end
        return (changes <= 1);
    endfunction

    assign legal_o = is_legal(q);

    always_comb begin
        if (load_i)         tr = TR_LOAD;
        else if (!adv_i)    tr = TR_HOLD;
        else if (!legal_o)  tr = TR_RECOVER;
        else                tr = TR_ADVANCE;
    end

    always_comb begin
        unique case (tr)
            TR_HOLD:    q_nxt = q;
            TR_ADVANCE: q_nxt = {q[TOP-1:0], ~q[TOP]};
            TR_RECOVER: q_nxt = '0;
            TR_LOAD:    q_nxt = seed_i;
            default:    q_nxt = q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    assign q_o = q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(q_o)); // R4
    AST_COUNT_LANDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> legal_o); // R11
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(seed_i))); // R10
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
    parameter int STAGES = 5
) (
    input  logic [STAGES-1:0]   q_i,
    output logic [2*STAGES-1:0] dec_o,
    output logic                carry_n_o
);
    localparam int TOP = STAGES - 1;

    for (genvar k = 0; k < STAGES; k++) begin : g_pair
        if (k == 0) begin : g_edge
            assign dec_o[0]      = ~q_i[TOP] & ~q_i[0];
            assign dec_o[STAGES] =  q_i[TOP] &  q_i[0];
        end else begin : g_mid
            assign dec_o[k]          =  q_i[k-1] & ~q_i[k];
            assign dec_o[STAGES + k] = ~q_i[k-1] &  q_i[k];
        end
    end

    assign carry_n_o = ~q_i[TOP];
endmodule

// File: rtl/jc_decade_counter.sv
module jc_decade_counter
    import jc_pkg::*;
#(
    parameter int STAGES = DEF_STAGES,
    parameter int SYNC   = DEF_SYNC
) (
    input  logic              clk,
    input  logic              mr_i,
    input  logic              cnt_rise_i,
    input  logic              cnt_fall_i,
    input  logic              seed_load_i,
    input  logic [STAGES-1:0] seed_i,
    output logic [2*STAGES-1:0] dec_o,
    output logic              carry_n_o
);
    localparam int STATES = 2 * STAGES;

    logic              rst_n;
    logic [1:0]        cnt_s;
    logic              adv;
    logic              legal;
    logic [STAGES-1:0] q;

    jc_reset_sync #(.DEPTH(SYNC)) u_rst (
        .clk     (clk),
        .arst_i  (mr_i),
        .rst_n_o (rst_n)
    );

    jc_sync #(.WIDTH(2), .DEPTH(SYNC)) u_sync (
        .clk (clk),
        .d_i ({cnt_fall_i, cnt_rise_i}),
        .q_o (cnt_s)
    );

    jc_count_qual u_qual (
        .clk      (clk),
        .rise_s_i (cnt_s[0]),
        .fall_s_i (cnt_s[1]),
        .adv_o    (adv)
    );

    jc_ring_core #(.STAGES(STAGES)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .load_i  (seed_load_i),
        .seed_i  (seed_i),
        .q_o     (q),
        .legal_o (legal)
    );

    jc_decode #(.STAGES(STAGES)) u_dec (
        .q_i       (q),
        .dec_o     (dec_o),
        .carry_n_o (carry_n_o)
    );

    AST_COUNT_NEEDS_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (cnt_s[0] && !cnt_s[1])); // R4
    AST_ONEHOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        legal |-> $onehot(dec_o)); // R8
    AST_CARRY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        legal |-> (carry_n_o == ~|dec_o[STATES-1:STAGES])); // R9
endmodule

// File: tb/tb_jc_decade_counter.sv
module tb_jc_decade_counter;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [9:0] dec;
        logic       carry_n;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       rise = 1'b0;
    logic       fall = 1'b0;
    logic       load = 1'b0;
    logic [4:0] seed = '0;
    logic [9:0] dec;
    logic       carry_n;

    int   total = 0;
    int   bad = 0;
    int   ref_k = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    jc_decade_counter dut (
        .clk(clk), .mr_i(mr), .cnt_rise_i(rise), .cnt_fall_i(fall),
        .seed_load_i(load), .seed_i(seed), .dec_o(dec), .carry_n_o(carry_n)
    );

    function automatic logic [4:0] jcode(int k);
        if (k <= 5) return 5'((32'd1 << k) - 1);
        return 5'h1F & ~5'((32'd1 << (k - 5)) - 1);
    endfunction

    task automatic check(logic [10:0] act, logic [10:0] expv, string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, expv);
        end
    endtask

    // driver side of the scoreboard
    task automatic push(int k, string tag);
        exp_t e;
        e.dec = 10'b1 << k;
        e.carry_n = (k < 5);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({carry_n, dec}, {e.carry_n, e.dec}, e.tag);
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic count_step(string tag);
        rise = 1'b1; settle(); ref_k = (ref_k + 1) % 10; push(ref_k, tag);
        rise = 1'b0; settle(); push(ref_k, "R4 rise falling no count");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R6 reset state
        repeat (3) @(negedge clk);
        push(0, "R6 reset state");
        @(negedge clk);
        mr = 1'b0; settle(); push(0, "R7 idle after release");

        // R1 R2 R8 R9 full sequence with wrap
        for (int i = 0; i < 12; i++) count_step("R2 R1 R8 R9 rise count");

        // R3 falling count while rise held high
        rise = 1'b1; settle(); ref_k = (ref_k + 1) % 10; push(ref_k, "R2 rise");
        for (int i = 0; i < 3; i++) begin
            fall = 1'b1; settle(); push(ref_k, "R4 fall rising no count");
            fall = 1'b0; settle(); ref_k = (ref_k + 1) % 10; push(ref_k, "R3 fall count");
        end

        // R4 ignored combinations
        rise = 1'b0; settle(); push(ref_k, "R4 rise falling");
        fall = 1'b1; settle(); push(ref_k, "R4 fall rising rise low");
        rise = 1'b1; settle(); push(ref_k, "R4 rise while fall high");
        rise = 1'b0; settle(); push(ref_k, "R4 rise falling fall high");
        fall = 1'b0; settle(); push(ref_k, "R4 fall falling rise low");

        // R5 coincident qualifying edges
        fall = 1'b1; settle(); push(ref_k, "R4 setup");
        rise = 1'b1; fall = 1'b0; settle();
        ref_k = (ref_k + 1) % 10; push(ref_k, "R5 single advance");
        rise = 1'b0; settle(); push(ref_k, "R4 after R5");

        // R6 asynchronous reset mid-cycle and held
        @(posedge clk); #2;
        mr = 1'b1; #1;
        check({carry_n, dec}, {1'b1, 10'b1}, "R6 async reset");
        rise = 1'b1; settle(); rise = 1'b0; settle();
        push(0, "R6 counts ignored in reset");
        // R7 first count after release
        mr = 1'b0; @(negedge clk);
        rise = 1'b1; settle(); ref_k = 1; push(1, "R7 first count");
        rise = 1'b0; settle(); push(1, "R7 no duplicate");

        // R10 load, and load beating a count
        seed = 5'b00111; load = 1'b1; @(negedge clk); load = 1'b0;
        ref_k = 3; push(3, "R10 load");
        rise = 1'b1; repeat (2) @(negedge clk);
        seed = 5'b11000; load = 1'b1; @(negedge clk); load = 1'b0;
        settle(); ref_k = 8; push(8, "R10 load over count");
        rise = 1'b0; settle(); push(8, "R10 held");

        // R11 every code, recovery then a full reference walk
        for (int c = 0; c < 32; c++) begin
            int k0;
            int n;
            k0 = -1;
            for (int k = 0; k < 10; k++) if (jcode(k) == 5'(c)) k0 = k;
            seed = 5'(c); load = 1'b1; @(negedge clk); load = 1'b0; settle();
            n = 0;
            if (k0 < 0) begin
                while (n < 11 && k0 < 0) begin
                    rise = 1'b1; settle(); rise = 1'b0; settle(); n++;
                    if ($countones(dec) == 1) begin
                        for (int k = 0; k < 10; k++) if (dec[k]) k0 = k;
                        if (carry_n !== (k0 < 5)) k0 = -1;
                    end
                end
                check({10'b0, k0 == 0}, 11'd1, $sformatf("R11 code %0d recovery to S0", c));
                check({7'b0, 4'(n)}, 11'd1, $sformatf("R11 code %0d counts used", c));
                if (k0 < 0) k0 = 0;
            end else begin
                check({carry_n, dec}, {k0 < 5, 10'b1 << k0}, "R10 R8 legal seed");
            end
            ref_k = k0;
            for (int i = 0; i < 10; i++) count_step("R11 R1 walk after seed");
        end

        settle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule